// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block sits between raw interrupt sources and the interrupt controllers. It takes a wide vector of raw request lines, grouped into banks of 32, and turns each one into a clean request according to a per-line trigger mode. A line can pass straight through as an active-high level, pass through inverted as an active-low level, or be edge-triggered on its rising or falling transition. Edge-triggered lines hold their request in a latch until software acknowledges it.

Software controls the block through a simple word-wide register port. Each bank has two configuration words, one "rise" bit and one "fall" bit per line, and these two bits together set the mode. The words can be written whole. They can also be changed bit by bit through set and clear alias addresses, so that one driver can change one line without a read-modify-write. A raw latch word lets software see pending edges and clear them by writing ones. A status word shows the conditioned outputs.

Top module: `trig_cond`

## Requirements
- R1: After reset, every rise and fall configuration bit is zero, every edge latch is clear, and with all lines low every `irq_o` bit is low.
- R2: Bank `b` occupies byte addresses `b*0x20` to `b*0x20+0x1F`. Inside a bank, the rise configuration word is at offset 0x08 and the fall configuration word at 0x0C. Both are read/write, and a write to one bank leaves every other bank unchanged.
- R3: Writing to offset 0x10 sets, and writing to 0x14 clears, the rise bits that are one in the data. Offsets 0x18 and 0x1C do the same for the fall bits. Configuration bits written as zero are left unchanged.
- R4: With rise=0 and fall=0 (active-high level), `irq_o` equals the line as registered once. It follows a change one clock later.
- R5: With rise=1 and fall=1 (active-low level), `irq_o` is the inverse of the registered line.
- R6: With rise=1 and fall=0 (rising edge), a 0-to-1 transition of the line sets the line's latch, and `irq_o` shows the latch. The request appears two clocks after the line changes and stays high after the line drops.
- R7: With rise=0 and fall=1 (falling edge), a 1-to-0 transition of the line sets the latch, and `irq_o` shows the latch.
- R8: Writing to offset 0x04 clears each latch whose data bit is one and leaves latches with a zero data bit unchanged. A single all-ones write clears the whole bank.
- R9: If a line detects an edge in the same clock that a clear write names it, its latch stays set.
- R10: A read returns its data on `rdata_o` one clock after the request. Offset 0x00 returns the bank's `irq_o` bits, 0x04 the latches, 0x08 and 0x0C the configuration words, and the four alias offsets return zero.
- R11: In the two level modes the output ignores the latch, and the latch keeps its value. Returning to an edge mode shows it again.
- R12: In the two level modes no transition sets a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (6) | Byte address; bits [4:2] select the register, the bits above select the bank |
| wdata_i | input | BANK_W (32) | Write data |
| rdata_o | output | BANK_W (32) | Read data, valid the clock after a read request |
| line_i | input | NUM_LINES (64) | Raw interrupt lines |
| irq_o | output | NUM_LINES (64) | Conditioned request lines |

## Verification
The hardest case to reach is an edge whose detection falls in the very clock where a clear write names the same line (R9). The bench first latches two lines. It then lets one of them drop, raises it again on a falling clock edge, and issues the all-ones clear at the next falling edge. In that way the register write is captured on exactly the rising edge where the registered sample and the previous sample differ. The main sweep covers every mode in both banks, including a per-bit mixture of modes, over several pairs of old and new line patterns. For each pair, the expected status and latch words are computed bitwise from the mode equations.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  // Register index inside a bank: byte address bits [4:2]
  typedef enum logic [2:0] {
    REG_STATUS   = 3'd0,
    REG_RAW      = 3'd1,
    REG_RISE     = 3'd2,
    REG_FALL     = 3'd3,
    REG_RISE_SET = 3'd4,
    REG_RISE_CLR = 3'd5,
    REG_FALL_SET = 3'd6,
    REG_FALL_CLR = 3'd7
  } reg_idx_e;

  localparam int unsigned BANK_ADDR_LSB = 5;
endpackage

// File: rtl/trig_line.sv
module trig_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic ack_i,
  output logic out_o,
  output logic pend_o
);
  logic samp_q, prev_q, pend_q, edge_hit;

  assign edge_hit = (rise_i & ~fall_i & samp_q & ~prev_q)
                  | (~rise_i & fall_i & ~samp_q & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      samp_q <= line_i;
      prev_q <= samp_q;
      pend_q <= (pend_q & ~ack_i) | edge_hit;  // new edge wins over ack
    end
  end

  // edge modes show the latch, level modes the sample (inverted when both set)
  assign out_o  = (rise_i ^ fall_i) ? pend_q : (samp_q ^ fall_i);
  assign pend_o = pend_q;

  assert_rise_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !fall_i && samp_q && !prev_q) |=> pend_q);
  assert_fall_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && fall_i && !samp_q && prev_q) |=> pend_q);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ((rise_i == fall_i) || (samp_q == prev_q))) |=> !pend_q);
  assert_level_no_latch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && (rise_i == fall_i)) |=> !pend_q);
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_cond_pkg::*;
#(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_idx_e          idx_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] line_i,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] rise_o,
  output logic [BANK_W-1:0] fall_o
);
  logic [BANK_W-1:0] rise_q, fall_q, ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        REG_RISE:     rise_q <= wdata_i;
        REG_RISE_SET: rise_q <= rise_q | wdata_i;
        REG_RISE_CLR: rise_q <= rise_q & ~wdata_i;
        REG_FALL:     fall_q <= wdata_i;
        REG_FALL_SET: fall_q <= fall_q | wdata_i;
        REG_FALL_CLR: fall_q <= fall_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign ack = (wr_i && idx_i == REG_RAW) ? wdata_i : '0;

  for (genvar i = 0; i < BANK_W; i++) begin : g_line
    trig_line u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_i[i]),
      .rise_i (rise_q[i]),
      .fall_i (fall_q[i]),
      .ack_i  (ack[i]),
      .out_o  (out_o[i]),
      .pend_o (pend_o[i])
    );
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_rise_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == REG_RISE_SET) |=>
      (rise_q == ($past(rise_q) | $past(wdata_i))));
  assert_fall_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == REG_FALL_CLR) |=>
      (fall_q == ($past(fall_q) & ~$past(wdata_i))));
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_cond_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W,
  localparam int unsigned BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W    = BANK_ADDR_LSB + BSEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BANK_W-1:0]    wdata_i,
  output logic [BANK_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [BSEL_W-1:0] bank_sel;
  reg_idx_e          idx;
  logic [1:0]        unused_byte;
  logic [BANK_W-1:0] rd_word, rdata_q;
  logic [BANK_W-1:0] b_out  [NUM_BANKS];
  logic [BANK_W-1:0] b_pend [NUM_BANKS];
  logic [BANK_W-1:0] b_rise [NUM_BANKS];
  logic [BANK_W-1:0] b_fall [NUM_BANKS];

  assign bank_sel    = addr_i[BANK_ADDR_LSB +: BSEL_W];
  assign idx         = reg_idx_e'(addr_i[4:2]);
  assign unused_byte = addr_i[1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    trig_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req_i && we_i && (bank_sel == BSEL_W'(b))),
      .idx_i   (idx),
      .wdata_i (wdata_i),
      .line_i  (line_i[b*BANK_W +: BANK_W]),
      .out_o   (b_out[b]),
      .pend_o  (b_pend[b]),
      .rise_o  (b_rise[b]),
      .fall_o  (b_fall[b])
    );
    assign irq_o[b*BANK_W +: BANK_W] = b_out[b];
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        unique case (idx)
          REG_STATUS: rd_word = b_out[b];
          REG_RAW:    rd_word = b_pend[b];
          REG_RISE:   rd_word = b_rise[b];
          REG_FALL:   rd_word = b_fall[b];
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  assert_read_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx == REG_STATUS && bank_sel == '0) |=>
      (rdata_o == $past(irq_o[BANK_W-1:0])));
  assert_alias_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[4]) |=> (rdata_o == '0));
  assert_read_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/trig_cond_test.sv
module trig_cond_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] line = '0;
  logic [63:0] irq;
  int n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #4ns clk = ~clk;

  trig_cond uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .line_i(line), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 6'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 6'(a);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] exp_out(logic [31:0] r, f, p0, p1);
    return (~r & ~f & p1) | (r & f & ~p1) | (r & ~f & p1 & ~p0) | (~r & f & ~p1 & p0);
  endfunction

  function automatic logic [31:0] exp_raw(logic [31:0] r, f, p0, p1);
    return (r & ~f & p1 & ~p0) | (~r & f & ~p1 & p0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] p0s [4];
    logic [31:0] p1s [4];
    p0s = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h1234_5678};
    p1s = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h3C3C_3C3C, 32'h8765_4321};

    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq", irq[31:0], 32'h0);
    chk("R1 irq hi", irq[63:32], 32'h0);
    rd(32'h08, rv); chk("R1 rise", rv, 32'h0);
    rd(32'h0C, rv); chk("R1 fall", rv, 32'h0);
    rd(32'h24, rv); chk("R1 raw", rv, 32'h0);

    // R2 bank separation
    wr(32'h28, 32'h1357_2468);
    rd(32'h08, rv); chk("R2 bank0 rise untouched", rv, 32'h0);
    rd(32'h28, rv); chk("R2 bank1 rise", rv, 32'h1357_2468);
    wr(32'h0C, 32'hCAFE_0001);
    rd(32'h2C, rv); chk("R2 bank1 fall untouched", rv, 32'h0);
    rd(32'h0C, rv); chk("R2 bank0 fall", rv, 32'hCAFE_0001);

    // R3 aliases
    wr(32'h08, 32'h0000_FFFF);
    wr(32'h10, 32'hF000_0001);
    rd(32'h08, rv); chk("R3 rise set", rv, 32'hF000_FFFF);
    wr(32'h14, 32'h0000_000F);
    rd(32'h08, rv); chk("R3 rise clr", rv, 32'hF000_FFF0);
    wr(32'h38, 32'h00FF_0000);
    rd(32'h2C, rv); chk("R3 fall set bank1", rv, 32'h00FF_0000);
    wr(32'h3C, 32'h0F0F_0000);
    rd(32'h2C, rv); chk("R3 fall clr bank1", rv, 32'h00F0_0000);
    rd(32'h10, rv); chk("R10 alias read", rv, 32'h0);
    rd(32'h3C, rv); chk("R10 alias read hi", rv, 32'h0);

    // R4 and R6 latency on bank0 bit 0
    wr(32'h08, 32'h0); wr(32'h0C, 32'h0); wr(32'h04, 32'hFFFF_FFFF);
    line[0] = 1'b1; step(1);
    chk("R4 level follows in one clock", {31'h0, irq[0]}, 32'h1);
    line[0] = 1'b0; step(2);
    wr(32'h08, 32'h1); wr(32'h04, 32'hFFFF_FFFF);
    line[0] = 1'b1; step(1);
    chk("R6 not yet latched", {31'h0, irq[0]}, 32'h0);
    step(1);
    chk("R6 latched after two clocks", {31'h0, irq[0]}, 32'h1);
    line[0] = 1'b0; step(2);
    chk("R6 held after line drops", {31'h0, irq[0]}, 32'h1);

    // R11 latch ignored in level mode, then shown again
    wr(32'h08, 32'h0);
    chk("R11 level ignores latch", {31'h0, irq[0]}, 32'h0);
    rd(32'h04, rv); chk("R11 latch kept", rv, 32'h1);
    wr(32'h08, 32'h1);
    chk("R11 latch shown again", {31'h0, irq[0]}, 32'h1);

    // R8 partial acknowledge
    wr(32'h08, 32'hFFFF_FFFF); wr(32'h04, 32'hFFFF_FFFF);
    line[31:0] = 32'h0000_00FF; step(2);
    wr(32'h04, 32'h0000_000F);
    rd(32'h04, rv); chk("R8 partial ack", rv, 32'h0000_00F0);
    wr(32'h04, 32'hFFFF_FFFF);
    rd(32'h04, rv); chk("R8 all-ones ack", rv, 32'h0);

    // R9 edge coincides with ack
    line[31:0] = 32'h0; step(2);
    line[1:0] = 2'b11; step(2);
    line[0] = 1'b0; step(2);
    line[0] = 1'b1;
    wr(32'h04, 32'hFFFF_FFFF);
    rd(32'h04, rv); chk("R9 edge beats ack", rv, 32'h1);
    line = '0; step(2);

    // Sweep: every mode per bank plus a mixed configuration
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 5; m++) begin
        logic [31:0] r, f;
        string tag_o, tag_r;
        case (m)
          0: begin r = '0;           f = '0;           tag_o = "R4"; tag_r = "R12"; end
          1: begin r = '0;           f = '1;           tag_o = "R7"; tag_r = "R7";  end
          2: begin r = '1;           f = '0;           tag_o = "R6"; tag_r = "R6";  end
          3: begin r = '1;           f = '1;           tag_o = "R5"; tag_r = "R12"; end
          default: begin r = 32'hA5A5_A5A5; f = 32'h0FF0_0FF0; tag_o = "R4 R5 R6 R7 mix"; tag_r = "R8 R12 mix"; end
        endcase
        wr(b*32 + 8, r);
        wr(b*32 + 12, f);
        for (int k = 0; k < 4; k++) begin
          line[b*32 +: 32] = p0s[k];
          step(3);
          wr(b*32 + 4, 32'hFFFF_FFFF);
          line[b*32 +: 32] = p1s[k];
          step(2);
          chk(tag_o, irq[b*32 +: 32], exp_out(r, f, p0s[k], p1s[k]));
          rd(b*32, rv);
          chk("R10 status", rv, exp_out(r, f, p0s[k], p1s[k]));
          rd(b*32 + 4, rv);
          chk(tag_r, rv, exp_raw(r, f, p0s[k], p1s[k]));
        end
        line[b*32 +: 32] = '0;
        step(3);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule